// File: doc/BRIEF.md
# Status Register Auto-Polling Matcher

This block sits beside a serial-memory phase sequencer and takes care of waiting on a device status register. Once started, it asks the sequencer to issue a status-read command, takes the status word that comes back, and tests it against a programmed compare value under a bit-select mask. Between two reads it idles for a programmed number of clock cycles. Software never has to re-issue the read itself.

The compare has two modes. In all-bits mode, every selected bit must equal its compare bit. In any-bit mode, a single equal selected bit is enough. The status word is one to four bytes wide, and only the bits inside that width take part in the compare. A sticky flag records any match until it is cleared with a write-one strobe. Polling ends in one of two ways: on the first match when self-stop is on, or by an abort. An abort during the interval wait takes effect at once. An abort while a read is outstanding waits for that read to come back.

Top module: `status_poll_matcher`

## Requirements
- R1: After reset, `busy`, `launch` and `match_flag` are all 0.
- R2: A `start` pulse while idle makes `launch` high for exactly the next cycle, and `busy` stays high until polling ends. A `start` pulse while busy has no effect on the launch timing.
- R3: `cfg_size` selects the status width: code 0 is 1 byte, 1 is 2 bytes, 2 is 3 bytes and 3 is 4 bytes. Only bits below 8×(code+1) of the data, mask and compare value take part. Higher bits never affect the result.
- R4: With `cfg_or_mode`=0, a match needs every bit with mask bit 1 to equal its compare bit. If no bit is selected, the read counts as a match.
- R5: With `cfg_or_mode`=1, a match needs at least one selected bit equal to its compare bit. If no bit is selected, the read never matches.
- R6: `rd_done` may be sampled at clock edge k, with polling going on. The next `launch` is then high in the cycle after edge k+`cfg_interval` (interval 0 to 65535).
- R7: With `cfg_auto_stop`=1, a matching read ends polling: `busy` is 0 in the cycle after the `rd_done` edge. With `cfg_auto_stop`=0, polling goes on after a match.
- R8: `match_flag` rises in the cycle after a matching `rd_done`. It stays set until `match_clr`. A match in the same cycle as `match_clr` leaves it set.
- R9: `abort` during the interval wait drops `busy` in the next cycle, and no further `launch` follows.
- R10: `abort` while a read is outstanding lets that read finish. Its match result still updates `match_flag`, and polling then ends with no further `launch`.
- R11: `rd_done` while no read is outstanding is ignored: `match_flag` and `busy` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_match | input | 32 | Compare value |
| cfg_mask | input | 32 | Bit-select mask (1 = bit takes part) |
| cfg_interval | input | 16 | Idle cycles between reads |
| cfg_size | input | 2 | Status width code (0..3 = 1..4 bytes) |
| cfg_or_mode | input | 1 | 0 = all selected bits, 1 = any selected bit |
| cfg_auto_stop | input | 1 | Stop on first match |
| start | input | 1 | Begin polling (idle only) |
| abort | input | 1 | End polling |
| match_clr | input | 1 | Write-one clear of the match flag |
| rd_data | input | 32 | Status word from the sequencer |
| rd_done | input | 1 | Status word valid strobe |
| launch | output | 1 | Request the sequencer to issue a status read |
| match_flag | output | 1 | Sticky status-match flag |
| busy | output | 1 | Polling in progress |

## Verification
The bench sets status data that matches in the low byte but differs above the selected width. A design that ignores `cfg_size` would stop early or keep polling here. It also programs an empty mask in both compare modes, where a wrong reduction flips the result. The interval gap is counted cycle by cycle for zero and non-zero values, which exposes off-by-one counters. Aborts are placed in the wait and inside a read: a design that drops an outstanding read loses its flag update. A same-cycle clear and match checks that a new match is not lost.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_READ   = 2'd2,
    ST_GAP    = 2'd3
  } spm_state_t;
endpackage

// File: rtl/spm_compare.sv
module spm_compare #(
  parameter int DW  = 32,
  parameter int SZW = 2
) (
  input  logic [DW-1:0]  data,
  input  logic [DW-1:0]  match_val,
  input  logic [DW-1:0]  mask,
  input  logic [SZW-1:0] size,
  input  logic           or_mode,
  output logic           hit
);
  localparam int LANES = DW / 8;

  logic [DW-1:0] part;
  logic [DW-1:0] eq;

  // Each byte lane takes part only when it lies inside the status width.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    assign lane_on         = (g <= int'(size));
    assign part[g*8 +: 8]  = mask[g*8 +: 8] & {8{lane_on}};
    assign eq[g*8 +: 8]    = ~(data[g*8 +: 8] ^ match_val[g*8 +: 8]);
  end

  always_comb begin
    if (or_mode) hit = |(eq & part);
    else         hit = &(eq | ~part);
  end
endmodule

// File: rtl/spm_gap_timer.sv
module spm_gap_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  input  logic          run,
  output logic          expired
);
  logic [IW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - {{(IW-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       rd_done,
  input  logic       hit,
  input  logic       auto_stop,
  input  logic       interval_zero,
  input  logic       gap_expired,
  output spm_state_t state,
  output logic       load_gap,
  output logic       eval
);
  spm_state_t state_q, state_d;
  logic       pend_q, pend_d;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    load_gap = 1'b0;
    eval     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (start) state_d = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        if (abort) pend_d = 1'b1;
        state_d = ST_READ;
      end
      ST_READ: begin
        if (abort) pend_d = 1'b1;
        if (rd_done) begin
          eval = 1'b1;
          if ((hit && auto_stop) || abort || pend_q) begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
          end else if (interval_zero) begin
            state_d = ST_LAUNCH;
          end else begin
            state_d  = ST_GAP;
            load_gap = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (abort)            state_d = ST_IDLE;
        else if (gap_expired) state_d = ST_LAUNCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/spm_flag.sv
module spm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  // A new match outranks a clear in the same cycle.
  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/status_poll_matcher.sv
module status_poll_matcher
  import spm_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IW  = 16,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  cfg_match,
  input  logic [DW-1:0]  cfg_mask,
  input  logic [IW-1:0]  cfg_interval,
  input  logic [SZW-1:0] cfg_size,
  input  logic           cfg_or_mode,
  input  logic           cfg_auto_stop,
  input  logic           start,
  input  logic           abort,
  input  logic           match_clr,
  input  logic [DW-1:0]  rd_data,
  input  logic           rd_done,
  output logic           launch,
  output logic           match_flag,
  output logic           busy
);
  localparam logic [IW-1:0] ONE = {{(IW-1){1'b0}}, 1'b1};

  spm_state_t state;
  logic       hit;
  logic       load_gap;
  logic       eval;
  logic       gap_expired;
  logic       in_gap;
  logic       in_read;
  logic       interval_zero;

  assign interval_zero = (cfg_interval == '0);
  assign in_gap        = (state == ST_GAP);
  assign in_read       = (state == ST_READ);

  spm_compare #(.DW(DW), .SZW(SZW)) u_cmp (
    .data      (rd_data),
    .match_val (cfg_match),
    .mask      (cfg_mask),
    .size      (cfg_size),
    .or_mode   (cfg_or_mode),
    .hit       (hit)
  );

  spm_gap_timer #(.IW(IW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_gap),
    .load_val (cfg_interval - ONE),
    .run      (in_gap),
    .expired  (gap_expired)
  );

  spm_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .abort         (abort),
    .rd_done       (rd_done),
    .hit           (hit),
    .auto_stop     (cfg_auto_stop),
    .interval_zero (interval_zero),
    .gap_expired   (gap_expired),
    .state         (state),
    .load_gap      (load_gap),
    .eval          (eval)
  );

  spm_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (eval & hit),
    .clr   (match_clr),
    .flag  (match_flag)
  );

  assign launch = (state == ST_LAUNCH);
  assign busy   = (state != ST_IDLE);
endmodule

// File: rtl/spm_checker.sv
module spm_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic abort,
  input logic rd_done,
  input logic match_clr,
  input logic cfg_auto_stop,
  input logic hit,
  input logic in_gap,
  input logic in_read,
  input logic launch,
  input logic busy,
  input logic match_flag
);
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !launch);                                   // R2
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) launch |=> !launch);                                  // R2
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> launch);                          // R2
  AST_AUTO_STOP:    assert property (@(posedge clk) disable iff (!rst_n) (in_read && rd_done && hit && cfg_auto_stop) |=> !busy); // R7
  AST_FLAG_SET:     assert property (@(posedge clk) disable iff (!rst_n) (in_read && rd_done && hit) |=> match_flag);          // R8
  AST_FLAG_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (match_flag && !match_clr) |=> match_flag);           // R8
  AST_ABORT_GAP:    assert property (@(posedge clk) disable iff (!rst_n) (in_gap && abort) |=> !busy);                         // R9
  AST_STRAY_DONE:   assert property (@(posedge clk) disable iff (!rst_n) (!busy && rd_done && !match_flag) |=> !match_flag);   // R11
endmodule

bind status_poll_matcher spm_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .abort         (abort),
  .rd_done       (rd_done),
  .match_clr     (match_clr),
  .cfg_auto_stop (cfg_auto_stop),
  .hit           (hit),
  .in_gap        (in_gap),
  .in_read       (in_read),
  .launch        (launch),
  .busy          (busy),
  .match_flag    (match_flag)
);

// File: tb/status_poll_matcher_tb.sv
`timescale 1ns/1ps
module status_poll_matcher_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_match, cfg_mask;
  logic [15:0] cfg_interval;
  logic [1:0]  cfg_size;
  logic        cfg_or_mode, cfg_auto_stop;
  logic        start, abort, match_clr, rd_done;
  logic [31:0] rd_data;
  logic        launch, match_flag, busy;

  int checks   = 0;
  int failures = 0;

  status_poll_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_match(cfg_match), .cfg_mask(cfg_mask),
    .cfg_interval(cfg_interval), .cfg_size(cfg_size), .cfg_or_mode(cfg_or_mode),
    .cfg_auto_stop(cfg_auto_stop), .start(start), .abort(abort), .match_clr(match_clr),
    .rd_data(rd_data), .rd_done(rd_done), .launch(launch), .match_flag(match_flag),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic set_cfg(input logic [31:0] m, input logic [31:0] k, input logic [15:0] iv,
                         input logic [1:0] sz, input logic orm, input logic as);
    cfg_match = m; cfg_mask = k; cfg_interval = iv; cfg_size = sz;
    cfg_or_mode = orm; cfg_auto_stop = as;
  endtask

  task automatic start_poll(input string req);
    start = 1'b1; step(); start = 1'b0;
    chk({req, " launch after start"}, launch, 1);
    chk({req, " busy after start"}, busy, 1);
    step();
  endtask

  task automatic respond(input logic [31:0] d);
    rd_data = d; rd_done = 1'b1; step(); rd_done = 1'b0;
  endtask

  task automatic pulse_clr();
    match_clr = 1'b1; step(); match_clr = 1'b0;
  endtask

  task automatic abort_in_gap(input string req);
    abort = 1'b1; step(); abort = 1'b0;
    chk({req, " abort in gap busy"}, busy, 0);
    chk({req, " abort in gap launch"}, launch, 0);
    for (int j = 0; j < 6; j++) begin step(); chk({req, " no launch after abort"}, launch, 0); end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 launch", launch, 0);
    chk("R1 flag", match_flag, 0);
  endtask

  task automatic t_and_size();
    set_cfg(32'h0000_005A, 32'hFFFF_FFFF, 16'd0, 2'd0, 1'b0, 1'b1);
    start_poll("R2");
    respond(32'hDEAD_BE5A);
    chk("R3 one byte ignores upper data", match_flag, 1);
    chk("R7 auto stop", busy, 0);
    pulse_clr();
    chk("R8 clear", match_flag, 0);
    set_cfg(32'h0000_005A, 32'h0000_FFFF, 16'd0, 2'd1, 1'b0, 1'b1);
    start_poll("R3");
    respond(32'h0000_115A);
    chk("R4 byte1 mismatch no match", match_flag, 0);
    chk("R7 continues on mismatch", busy, 1);
    chk("R6 zero interval relaunch", launch, 1);
    step();
    respond(32'hFFFF_005A);
    chk("R3 two byte match", match_flag, 1);
    chk("R7 stop after match", busy, 0);
    pulse_clr();
    set_cfg(32'h8000_0000, 32'hFFFF_FFFF, 16'd0, 2'd3, 1'b0, 1'b1);
    start_poll("R3");
    respond(32'h8000_0000);
    chk("R3 four byte match", match_flag, 1);
    pulse_clr();
    set_cfg(32'h1234_5678, 32'h0000_0000, 16'd0, 2'd3, 1'b0, 1'b1);
    start_poll("R4");
    respond(32'h0000_0000);
    chk("R4 empty mask matches in all-bits mode", match_flag, 1);
    pulse_clr();
  endtask

  task automatic t_or();
    set_cfg(32'h0000_0000, 32'h0000_000F, 16'd0, 2'd0, 1'b1, 1'b1);
    start_poll("R5");
    respond(32'h0000_00FE);
    chk("R5 one equal bit matches", match_flag, 1);
    chk("R5 stop", busy, 0);
    pulse_clr();
    start_poll("R5");
    respond(32'h0000_000F);
    chk("R5 no equal bit", match_flag, 0);
    chk("R5 still polling", busy, 1);
    step();
    respond(32'h0000_00F0);
    chk("R5 later match", match_flag, 1);
    pulse_clr();
    set_cfg(32'h0000_0000, 32'h0000_0000, 16'd4, 2'd3, 1'b1, 1'b1);
    start_poll("R5");
    respond(32'h0000_0000);
    chk("R5 empty mask never matches", match_flag, 0);
    chk("R5 empty mask keeps polling", busy, 1);
    abort_in_gap("R9");
  endtask

  task automatic t_interval();
    set_cfg(32'h0000_0000, 32'h0000_00FF, 16'd3, 2'd0, 1'b0, 1'b0);
    start_poll("R6");
    respond(32'h0000_0001);
    for (int j = 0; j < 3; j++) begin
      chk("R6 no early launch", launch, 0);
      if (j == 1) start = 1'b1;
      step();
      start = 1'b0;
    end
    chk("R6 launch after interval", launch, 1);
    chk("R2 start while busy ignored", busy, 1);
    step();
    cfg_interval = 16'd0;
    respond(32'h0000_0000);
    chk("R7 match without auto stop flag", match_flag, 1);
    chk("R7 polling continues", busy, 1);
    chk("R6 zero interval launch", launch, 1);
    step();
    cfg_interval = 16'd7;
    respond(32'h0000_0000);
    chk("R6 gap entered", launch, 0);
    abort_in_gap("R9");
    pulse_clr();
  endtask

  task automatic t_flag();
    set_cfg(32'h0000_0000, 32'h0000_00FF, 16'd0, 2'd0, 1'b0, 1'b1);
    start_poll("R8");
    respond(32'h0000_0000);
    chk("R8 set", match_flag, 1);
    start_poll("R8");
    match_clr = 1'b1;
    respond(32'h0000_0000);
    match_clr = 1'b0;
    chk("R8 set wins over clear", match_flag, 1);
    for (int j = 0; j < 3; j++) begin step(); chk("R8 sticky", match_flag, 1); end
    pulse_clr();
    chk("R8 cleared", match_flag, 0);
  endtask

  task automatic t_abort_read();
    set_cfg(32'h0000_0000, 32'h0000_00FF, 16'd0, 2'd0, 1'b0, 1'b0);
    start_poll("R10");
    abort = 1'b1; step(); abort = 1'b0;
    step();
    chk("R10 read still outstanding", busy, 1);
    respond(32'h0000_0000);
    chk("R10 flag from last read", match_flag, 1);
    chk("R10 stops after read", busy, 0);
    for (int j = 0; j < 4; j++) begin step(); chk("R10 no further launch", launch, 0); end
    pulse_clr();
  endtask

  task automatic t_stray();
    set_cfg(32'h0000_0000, 32'h0000_00FF, 16'd0, 2'd0, 1'b0, 1'b1);
    respond(32'h0000_0000);
    chk("R11 stray done flag", match_flag, 0);
    chk("R11 stray done busy", busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; abort = 1'b0; match_clr = 1'b0;
    rd_done = 1'b0; rd_data = '0;
    set_cfg(32'h0, 32'h0, 16'd0, 2'd0, 1'b0, 1'b0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_and_size();
    t_or();
    t_interval();
    t_flag();
    t_abort_read();
    t_stray();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule